// File: doc/BRIEF.md
# UART Receive Character Buffer

This block sits between a UART deserialiser and the register interface that software reads. It holds received characters, each one stored with four error bits: framing, parity, break and overrun. It can run in two modes. In the buffered mode it is a sixteen-entry first-in first-out queue. In the unbuffered mode it is a single holding register. The mode is chosen by an enable input. Whenever that input changes, the stored contents are discarded.

The entry at the head of the buffer is always presented on the read-data output. A read strobe consumes that entry and copies its error bits into a status register. The status register keeps those bits until a clear strobe arrives or another read replaces them. The block also provides receive-empty and receive-full flags and a level-type receive interrupt. The receiver input can be disconnected by a loopback control. While loopback is active, characters and break events from outside are dropped.

Entry layout (12 bits):

| Bits | Content |
|------|---------|
| 7:0 | data byte |
| 8 | framing error |
| 9 | parity error |
| 10 | break |
| 11 | overrun |

Top module: `uart_rx_buffer`

## Requirements
- R1: With `fifo_en` low the buffer holds at most one entry. With `fifo_en` high it holds up to 16 entries.
- R2: Entries leave in the order they arrived. `rd_data` always shows the entry at the head of the buffer, combinationally from the stored state.
- R3: `rx_empty` is high exactly when no entry is held. `rx_full` is high exactly when the held count equals the effective depth. Both flags change at the clock edge after the push or read that causes the change.
- R4: If `fifo_en` differs from the mode currently in use, the next edge does four things:
  - it empties the buffer;
  - it resets the read position;
  - it adopts the new mode;
  - it ignores any push or read in that cycle.
  The interrupt level is not changed by this flush.
- R5: A read in a cycle with no flush loads bits 11:8 of the head entry into `rx_status` at the next edge. A clear strobe without a read sets `rx_status` to zero. If both strobes arrive in the same cycle, the read wins.
- R6: A break event pushes the entry 12'h400, which is break bit 10 set and data byte zero. If a break event and a data push arrive in the same cycle, the break takes priority.
- R7: `rx_irq` is set when an accepted push brings the count to the trigger level, which is 1. It is cleared when a read leaves the count at trigger minus one, which is 0. A read of an empty buffer therefore also clears it.
- R8: While `loopback` is high, data pushes and break events are discarded.
- R9: A push is dropped when the buffer is full and no entry is being read in the same cycle. In that case bit 11 (overrun) of the newest stored entry is set. A push that arrives together with a read of a full buffer is accepted.
- R10: A read of an empty buffer leaves the count and the read position unchanged.
- R11: After reset the buffer is empty, is not full, and is in unbuffered mode, with `rx_irq` at 0 and `rx_status` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| push_valid | input | 1 | received character strobe |
| push_entry | input | 12 | received character with error bits |
| break_evt | input | 1 | break condition detected |
| dr_read | input | 1 | data register read strobe |
| stat_clr | input | 1 | write to receive status register |
| fifo_en | input | 1 | buffered mode enable |
| loopback | input | 1 | loopback active, external input disconnected |
| rd_data | output | 12 | head entry |
| rx_empty | output | 1 | receive buffer empty |
| rx_full | output | 1 | receive buffer full |
| rx_status | output | 4 | error bits of the last read entry |
| rx_irq | output | 1 | receive interrupt request level |

## Verification
The assertions that concern loopback, status clearing and empty reads take those behaviours as given only in cycles with no mode flush pending. They also treat a read strobe as overriding a status clear. The stimulus mixes every combination of strobes in a random phase. It toggles `fifo_en` only rarely, so that long runs without a flush occur. It also includes directed sequences in which reads, pushes and breaks arrive on a full buffer in the same cycle. The reference model runs the same rules as the requirements, cycle by cycle. When a read hits an empty buffer, the model marks the status value as unknown until the next defined update, because the read slot then holds stale contents.

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4,
  parameter int DEPTH  = 16,
  parameter int TRIG   = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push_valid,
  input  logic [DATA_W+ERR_W-1:0]   push_entry,
  input  logic                      break_evt,
  input  logic                      dr_read,
  input  logic                      stat_clr,
  input  logic                      fifo_en,
  input  logic                      loopback,
  output logic [DATA_W+ERR_W-1:0]   rd_data,
  output logic                      rx_empty,
  output logic                      rx_full,
  output logic [ERR_W-1:0]          rx_status,
  output logic                      rx_irq
);
  localparam int ENT_W   = DATA_W + ERR_W;
  localparam int PW      = $clog2(DEPTH);
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int BRK_BIT = DATA_W + 2;
  localparam int OVR_BIT = DATA_W + 3;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PW-1:0]    rptr;
  logic [CW-1:0]    cnt;
  logic             fen_q;

  function automatic logic [PW-1:0] wrap(input logic [PW-1:0] p, input logic en);
    return en ? p : '0;
  endfunction

  wire             flush     = fifo_en != fen_q;
  wire [CW-1:0]    depth_eff = fen_q ? CW'(DEPTH) : CW'(1);
  wire             src       = (push_valid | break_evt) & ~loopback;
  wire [ENT_W-1:0] src_ent   = break_evt ? (ENT_W'(1) << BRK_BIT) : push_entry;
  wire             is_full   = cnt == depth_eff;
  wire             is_empty  = cnt == '0;
  wire             pop       = dr_read & ~is_empty;
  wire             take      = src & (~is_full | pop);
  wire             ovr       = src & is_full & ~pop;
  wire [PW-1:0]    wslot     = wrap(rptr + PW'(cnt), fen_q);
  wire [PW-1:0]    lslot     = wrap(rptr + PW'(cnt) - PW'(1), fen_q);
  wire [CW-1:0]    cnt_nx    = cnt - CW'(pop) + CW'(take);

  assign rd_data  = mem[rptr];
  assign rx_empty = is_empty;
  assign rx_full  = is_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr      <= '0;
      cnt       <= '0;
      fen_q     <= 1'b0;
      rx_status <= '0;
      rx_irq    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (flush) begin
      fen_q <= fifo_en;
      rptr  <= '0;
      cnt   <= '0;
    end else begin
      cnt <= cnt_nx;
      if (pop) rptr <= wrap(rptr + PW'(1), fen_q);
      if (take) mem[wslot] <= src_ent;
      if (ovr) mem[lslot][OVR_BIT] <= 1'b1;
      if (dr_read) rx_status <= rd_data[ENT_W-1:DATA_W];
      else if (stat_clr) rx_status <= '0;
      if (take && cnt_nx == CW'(TRIG)) rx_irq <= 1'b1;
      else if (dr_read && cnt_nx == CW'(TRIG - 1)) rx_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_buffer_chk.sv
module uart_rx_buffer_chk #(
  parameter int CW    = 5,
  parameter int ERR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             break_evt,
  input logic             dr_read,
  input logic             stat_clr,
  input logic             fifo_en,
  input logic             loopback,
  input logic             rx_empty,
  input logic             rx_full,
  input logic             rx_irq,
  input logic [ERR_W-1:0] rx_status,
  input logic             fen_q,
  input logic [CW-1:0]    cnt
);
  wire src_in = (push_valid || break_evt) && !loopback;

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_empty && rx_full));

  p_single_depth_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fen_q |-> cnt <= CW'(1));

  p_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en != fen_q) |=> (rx_empty && !rx_full));

  p_status_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !dr_read && fifo_en == fen_q) |=> rx_status == '0);

  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && src_in && fifo_en == fen_q) |=> rx_irq);

  p_loop_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (loopback && !dr_read) |=> cnt <= $past(cnt));

  p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_read && rx_empty && !src_in && fifo_en == fen_q) |=> rx_empty);
endmodule

bind uart_rx_buffer uart_rx_buffer_chk #(.CW(CW), .ERR_W(ERR_W)) u_chk (.*);

// File: tb/uart_rx_buffer_bench.sv
`timescale 1ns/1ps
module uart_rx_buffer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [11:0] push_entry = '0;
  logic        break_evt = 1'b0;
  logic        dr_read = 1'b0;
  logic        stat_clr = 1'b0;
  logic        fifo_en = 1'b0;
  logic        loopback = 1'b0;
  logic [11:0] rd_data;
  logic        rx_empty, rx_full, rx_irq;
  logic [3:0]  rx_status;

  uart_rx_buffer u_uart_rx_buffer (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  logic [11:0] q[$];
  bit          fen_m = 0, irq_m = 0, stat_known = 1;
  logic [3:0]  stat_m = '0;

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int depth_m();
    return fen_m ? 16 : 1;
  endfunction

  task automatic model_edge();
    bit src, pop, full;
    logic [11:0] ent;
    if (fifo_en != fen_m) begin
      q.delete();
      fen_m = fifo_en;
      return;
    end
    full = q.size() == depth_m();
    pop  = dr_read && q.size() > 0;
    if (dr_read) begin
      if (q.size() > 0) begin stat_m = q[0][11:8]; stat_known = 1; end
      else stat_known = 0;
    end else if (stat_clr) begin
      stat_m = '0; stat_known = 1;
    end
    src = (push_valid || break_evt) && !loopback;
    ent = break_evt ? 12'h400 : push_entry;
    if (pop) void'(q.pop_front());
    if (src && (!full || pop)) begin
      q.push_back(ent);
      if (q.size() == 1) irq_m = 1;
    end else begin
      if (src) q[q.size()-1][11] = 1'b1;
      if (dr_read && q.size() == 0) irq_m = 0;
    end
  endtask

  task automatic compare_all();
    chk("R3 empty", {11'd0, rx_empty}, {11'd0, q.size() == 0});
    chk("R3 full", {11'd0, rx_full}, {11'd0, q.size() == depth_m()});
    chk("R7 irq", {11'd0, rx_irq}, {11'd0, irq_m});
    if (stat_known) chk("R5 status", {8'd0, rx_status}, {8'd0, stat_m});
    if (q.size() > 0) chk("R2 head data", rd_data, q[0]);
  endtask

  task automatic step(bit pv, logic [11:0] pe, bit brk, bit rd, bit clr, bit en, bit lb);
    push_valid = pv; push_entry = pe; break_evt = brk;
    dr_read = rd; stat_clr = clr; fifo_en = en; loopback = lb;
    @(posedge clk); #1;
    model_edge();
    @(negedge clk);
    compare_all();
    push_valid = 0; break_evt = 0; dr_read = 0; stat_clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 empty", {11'd0, rx_empty}, 12'd1);
    chk("R11 full", {11'd0, rx_full}, 12'd0);
    chk("R11 irq", {11'd0, rx_irq}, 12'd0);
    chk("R11 status", {8'd0, rx_status}, 12'd0);

    // R1 single holding register, R9 overrun on full
    step(1, 12'h041, 0, 0, 0, 0, 0);
    chk("R1 one entry fills", {11'd0, rx_full}, 12'd1);
    step(1, 12'h055, 0, 0, 0, 0, 0);
    chk("R9 overrun marked", rd_data, 12'h841);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R5 status loaded", {8'd0, rx_status}, 12'h008);
    // R10 read when empty
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R10 still empty", {11'd0, rx_empty}, 12'd1);
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R5 status cleared", {8'd0, rx_status}, 12'd0);
    // R9 full with simultaneous read accepts push
    step(1, 12'h1a3, 0, 0, 0, 0, 0);
    step(1, 12'h0b4, 0, 1, 0, 0, 0);
    chk("R9 push with read accepted", rd_data, 12'h0b4);
    step(0, 0, 0, 1, 0, 0, 0);

    // R4 enable buffered mode, R1 sixteen deep
    step(0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 16; i++) begin
      step(1, {i[3:0] & 4'h3, i[7:0] + 8'h30}, 0, 0, 0, 1, 0);
      chk("R1 not full early", {11'd0, rx_full}, {11'd0, i == 15});
    end
    step(1, 12'h0ff, 0, 0, 0, 1, 0);
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 0, 1, 0);
    chk("R2 drained", {11'd0, rx_empty}, 12'd1);
    chk("R9 last entry overrun", {8'd0, rx_status}, 12'h00b);

    // R6 break entry
    step(0, 0, 1, 0, 0, 1, 0);
    chk("R6 break entry", rd_data, 12'h400);
    step(0, 0, 1, 1, 0, 1, 0);
    step(0, 0, 0, 1, 0, 1, 0);
    chk("R6 break status", {8'd0, rx_status}, 12'h004);
    step(0, 0, 0, 1, 0, 1, 0);

    // R8 loopback discards
    step(1, 12'h077, 0, 0, 0, 1, 1);
    step(0, 0, 1, 0, 0, 1, 1);
    chk("R8 discarded", {11'd0, rx_empty}, 12'd1);

    // R4 flush with data keeps irq
    for (int i = 0; i < 3; i++) step(1, 12'h060 + 12'(i), 0, 0, 0, 1, 0);
    step(1, 12'h070, 0, 1, 0, 0, 0);
    chk("R4 flushed", {11'd0, rx_empty}, 12'd1);
    chk("R4 irq kept", {11'd0, rx_irq}, 12'd1);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R7 empty read clears irq", {11'd0, rx_irq}, 12'd0);

    // random mix
    begin
      bit en = 0;
      for (int n = 0; n < 4000; n++) begin
        if ($urandom_range(0, 59) == 0) en = ~en;
        step($urandom_range(0, 1), 12'($urandom), $urandom_range(0, 19) == 0,
             $urandom_range(0, 2) == 0, $urandom_range(0, 9) == 0, en,
             $urandom_range(0, 9) == 0);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule